// File: doc/BRIEF.md
# VLIW Packet Port-Conflict Checker

This block looks at every decoded execute packet of a two-sided VLIW datapath before issue and decides whether the packet would oversubscribe a register-file port. Each side has three issue slots: an arithmetic/logic slot L, a shift slot S and a data slot D. Every slot supplies a valid bit and four flags: it writes a 40-bit long result, it reads a 40-bit long source, it is a store, or it is a doubleword load. The block returns a legal flag and a reason vector in the same cycle, so issue logic can stall or trap on it.

Three of the conflicts lie inside a single packet. Two long writes on one side share a single long write port. A long read shares its port with the store path. The S unit's long source clashes with any store on that side. The fourth conflict spans cycles. A doubleword load writes back late, and an S-unit long write issued four packets after it lands in the same writeback cycle. A small per-side load history catches that case. Every clock cycle is one packet. An empty packet still ages the history.

Top module: `vliw_port_guard`

## Requirements
- R1: On one side, a valid L slot with a long result together with a valid S slot with a long result sets reason bit 0 and clears pkt_ok. Slot index is side*3+unit, with unit L=0, S=1, D=2 and side A=0, B=1.
- R2: One long result on side A and one on side B in the same packet, with nothing else present, leaves pkt_ok high and reason zero.
- R3: A valid store in the D slot together with a valid long source in the L or S slot of the same side sets reason bit 1.
- R4: A store on a side whose L slot writes a long result from ordinary sources (long_src clear) is legal.
- R5: A valid store in the D slot together with a valid long source in the S slot of the same side sets reason bit 2. Reason bit 1 is set as well.
- R6: A valid doubleword load in the D slot of a side at packet t, followed by a valid S-slot long result on that side at packet t+4, sets reason bit 3 at t+4. The same pair at a distance of 1, 2, 3, 5 or 6 packets sets no bit 3.
- R7: A slot whose valid bit is clear contributes nothing, whatever its flags hold. An all-empty packet is legal unless R6 applies.
- R8: Empty packets advance the load history by one entry each, just as full packets do.
- R9: While rst is high, pkt_ok is 1 and reason is 0. On each clock edge during reset the load history is cleared, so a load issued before reset causes no bit 3 afterwards.
- R10: Store and doubleword-load flags are used only from the D slot. Long-result flags count only from the L and S slots. Conditions on one side never raise a conflict through the other side.
- R11: pkt_ok is high exactly when no reason bit is set. More than one reason bit may be set at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one packet per cycle |
| rst | input | 1 | Synchronous reset, active high |
| slot_vld | input | 6 | Slot valid, index side*3+unit |
| long_dst | input | 6 | Slot writes a 40-bit long result |
| long_src | input | 6 | Slot reads a 40-bit long source |
| is_store | input | 6 | Slot is a store (D slots only) |
| dw_load | input | 6 | Slot is a doubleword load (D slots only) |
| pkt_ok | output | 1 | Packet is free of port conflicts |
| reason | output | 4 | Bit 0 double long write, bit 1 long read with store, bit 2 S long source with store, bit 3 load/long-write collision |

## Verification
The bench sweeps every combination of valid, long-result, long-source and store flags over the three slots of one side, with the other side quiet. It then repeats the sweep with the sides swapped, which separates same-side conflicts from cross-side independence and from the masking of invalid slots. It also varies the distance between a doubleword load and a later S-unit long write from one to six packets, with empty packets as filler, so that only a distance of four raises the collision and history aging by NOPs is visible. A long random run with all flags on both sides mixes the cross-cycle rule with the in-packet rules. Directed packets cover the legal pairings, flags placed on the wrong slots, and reset in the middle of a pending load.

// File: rtl/pg_pkg.sv
package pg_pkg;
   localparam int UNITS     = 3;
   localparam int U_L       = 0;
   localparam int U_S       = 1;
   localparam int U_D       = 2;
   localparam int REASON_W  = 4;
   localparam int RB_DBLWR  = 0;
   localparam int RB_LRDST  = 1;
   localparam int RB_SSRCST = 2;
   localparam int RB_LDCOL  = 3;

   typedef logic [REASON_W-1:0] reason_t;
endpackage

// File: rtl/pg_side_rules.sv
module pg_side_rules
   import pg_pkg::*;
(
   input  logic          l_vld,
   input  logic          s_vld,
   input  logic          d_vld,
   input  logic          l_ldst,
   input  logic          s_ldst,
   input  logic          l_lsrc,
   input  logic          s_lsrc,
   input  logic          d_store,
   input  logic          d_dwld,
   input  logic          ld_aged,
   output logic          ld_now,
   output reason_t       side_reason
);
   logic wr_l, wr_s, rd_l, rd_s, st_d;

   assign wr_l = l_vld & l_ldst;
   assign wr_s = s_vld & s_ldst;
   assign rd_l = l_vld & l_lsrc;
   assign rd_s = s_vld & s_lsrc;
   assign st_d = d_vld & d_store;

   assign ld_now = d_vld & d_dwld;

   always_comb begin
      side_reason            = '0;
      side_reason[RB_DBLWR]  = wr_l & wr_s;
      side_reason[RB_LRDST]  = st_d & (rd_l | rd_s);
      side_reason[RB_SSRCST] = st_d & rd_s;
      side_reason[RB_LDCOL]  = ld_aged & wr_s;
   end
endmodule

// File: rtl/pg_load_hist.sv
module pg_load_hist #(
   parameter int DEPTH = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic ld_in,
   output logic ld_aged
);
   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("pg_load_hist: DEPTH must be at least 1");
      end else if (DEPTH == 1) begin : g_single
         logic hold_q;
         always_ff @(posedge clk) begin
            if (rst) hold_q <= 1'b0;
            else     hold_q <= ld_in;
         end
         assign ld_aged = hold_q;
      end else begin : g_shift
         logic [DEPTH-1:0] sr_q;
         always_ff @(posedge clk) begin
            if (rst) sr_q <= '0;
            else     sr_q <= {sr_q[DEPTH-2:0], ld_in};
         end
         assign ld_aged = sr_q[DEPTH-1];
      end
   endgenerate
endmodule

// File: rtl/vliw_port_guard.sv
module vliw_port_guard
   import pg_pkg::*;
#(
   parameter int NSIDE  = 2,
   parameter int LD_GAP = 4
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic [NSIDE*UNITS-1:0]    slot_vld,
   input  logic [NSIDE*UNITS-1:0]    long_dst,
   input  logic [NSIDE*UNITS-1:0]    long_src,
   input  logic [NSIDE*UNITS-1:0]    is_store,
   input  logic [NSIDE*UNITS-1:0]    dw_load,
   output logic                      pkt_ok,
   output logic [REASON_W-1:0]       reason
);
   localparam int NSLOT = NSIDE * UNITS;

   generate
      if (NSIDE < 1) begin : g_bad_nside
         $error("vliw_port_guard: NSIDE must be at least 1");
      end
      if (LD_GAP < 1) begin : g_bad_gap
         $error("vliw_port_guard: LD_GAP must be at least 1");
      end
   endgenerate

   reason_t side_reason [NSIDE];
   reason_t reason_any;

   for (genvar s = 0; s < NSIDE; s++) begin : g_side
      localparam int B = s * UNITS;
      logic ld_now, ld_aged;

      pg_side_rules u_rules (
         .l_vld       (slot_vld[B+U_L]),
         .s_vld       (slot_vld[B+U_S]),
         .d_vld       (slot_vld[B+U_D]),
         .l_ldst      (long_dst[B+U_L]),
         .s_ldst      (long_dst[B+U_S]),
         .l_lsrc      (long_src[B+U_L]),
         .s_lsrc      (long_src[B+U_S]),
         .d_store     (is_store[B+U_D]),
         .d_dwld      (dw_load[B+U_D]),
         .ld_aged     (ld_aged),
         .ld_now      (ld_now),
         .side_reason (side_reason[s])
      );

      pg_load_hist #(.DEPTH(LD_GAP)) u_hist (
         .clk     (clk),
         .rst     (rst),
         .ld_in   (ld_now),
         .ld_aged (ld_aged)
      );
   end

   always_comb begin
      reason_any = '0;
      for (int s = 0; s < NSIDE; s++) reason_any |= side_reason[s];
   end

   assign reason = rst ? '0 : reason_any;
   assign pkt_ok = rst | ~(|reason_any);

   // flag bits with no meaning on their slot
   logic unused_bits;
   always_comb begin
      unused_bits = 1'b0;
      for (int k = 0; k < NSLOT; k++) begin
         if ((k % UNITS) == U_D)
            unused_bits = unused_bits ^ long_dst[k] ^ long_src[k];
         else
            unused_bits = unused_bits ^ is_store[k] ^ dw_load[k];
      end
   end
endmodule

// File: rtl/pg_guard_chk.sv
module pg_guard_chk
   import pg_pkg::*;
#(
   parameter int NSIDE  = 2,
   parameter int LD_GAP = 4
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic [NSIDE*UNITS-1:0]    slot_vld,
   input  logic [NSIDE*UNITS-1:0]    long_dst,
   input  logic [NSIDE*UNITS-1:0]    long_src,
   input  logic [NSIDE*UNITS-1:0]    is_store,
   input  logic [NSIDE*UNITS-1:0]    dw_load,
   input  logic                      pkt_ok,
   input  logic [REASON_W-1:0]       reason
);
   logic [NSIDE-1:0] col_seen;

   AST_RESET_LEGAL: assert property (@(posedge clk)
      rst |-> (pkt_ok && reason == '0)); // R9

   AST_EMPTY_LEGAL: assert property (@(posedge clk) disable iff (rst)
      (slot_vld == '0) |-> pkt_ok); // R7

   AST_NO_FALSE_COLLIDE: assert property (@(posedge clk) disable iff (rst)
      reason[RB_LDCOL] |-> (|col_seen)); // R6

   for (genvar s = 0; s < NSIDE; s++) begin : g_chk
      localparam int B = s * UNITS;
      logic [LD_GAP-1:0] shadow_q;
      logic wr_l, wr_s, rd_s, st_d;

      assign wr_l = slot_vld[B+U_L] & long_dst[B+U_L];
      assign wr_s = slot_vld[B+U_S] & long_dst[B+U_S];
      assign rd_s = slot_vld[B+U_S] & long_src[B+U_S];
      assign st_d = slot_vld[B+U_D] & is_store[B+U_D];
      assign col_seen[s] = shadow_q[LD_GAP-1] & wr_s;

      always_ff @(posedge clk) begin
         if (rst) shadow_q <= '0;
         else     shadow_q <= {shadow_q, slot_vld[B+U_D] & dw_load[B+U_D]} >> 0;
      end

      AST_DOUBLE_WRITE: assert property (@(posedge clk) disable iff (rst)
         (wr_l && wr_s) |-> (reason[RB_DBLWR] && !pkt_ok)); // R1

      AST_SRC_STORE: assert property (@(posedge clk) disable iff (rst)
         (st_d && rd_s) |-> (reason[RB_SSRCST] && reason[RB_LRDST])); // R5

      AST_LOAD_COLLIDE: assert property (@(posedge clk) disable iff (rst)
         col_seen[s] |-> (reason[RB_LDCOL] && !pkt_ok)); // R6
   end

   logic unused_chk;
   assign unused_chk = ^{long_src, is_store, dw_load, long_dst};
endmodule

bind vliw_port_guard pg_guard_chk #(.NSIDE(NSIDE), .LD_GAP(LD_GAP)) u_guard_chk (
   .clk      (clk),
   .rst      (rst),
   .slot_vld (slot_vld),
   .long_dst (long_dst),
   .long_src (long_src),
   .is_store (is_store),
   .dw_load  (dw_load),
   .pkt_ok   (pkt_ok),
   .reason   (reason)
);

// File: tb/vliw_port_guard_test.sv
module vliw_port_guard_test;
   localparam int CLK_NS = 8;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [5:0] v = '0, ld = '0, ls = '0, st = '0, lw = '0;
   logic       pkt_ok;
   logic [3:0] reason;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;
   logic [3:0] bh [2];

   always #(CLK_NS/2) clk = ~clk;

   vliw_port_guard uut (
      .clk(clk), .rst(rst), .slot_vld(v), .long_dst(ld), .long_src(ls),
      .is_store(st), .dw_load(lw), .pkt_ok(pkt_ok), .reason(reason)
   );

   function automatic logic [3:0] model();
      logic [3:0] r;
      r = '0;
      for (int s = 0; s < 2; s++) begin
         int b;
         logic wl, ws, rl, rs, sd;
         b  = s * 3;
         wl = v[b] & ld[b];
         ws = v[b+1] & ld[b+1];
         rl = v[b] & ls[b];
         rs = v[b+1] & ls[b+1];
         sd = v[b+2] & st[b+2];
         r[0] = r[0] | (wl & ws);
         r[1] = r[1] | (sd & (rl | rs));
         r[2] = r[2] | (sd & rs);
         r[3] = r[3] | (bh[s][3] & ws);
      end
      return r;
   endfunction

   // one packet: drive at negedge, check before the next posedge
   task automatic pkt(input logic [5:0] iv, ild, ils, ist, ilw, input string tag);
      logic [3:0] er;
      logic       eo;
      @(negedge clk);
      v = iv; ld = ild; ls = ils; st = ist; lw = ilw;
      #2;
      er = rst ? 4'b0 : model();
      eo = rst ? 1'b1 : (er == 4'b0);
      total++;
      if (reason !== er || pkt_ok !== eo) begin
         bad++;
         $display("FAIL %s: reason=%b pkt_ok=%b expected reason=%b pkt_ok=%b (v=%b ld=%b ls=%b st=%b lw=%b)",
                  tag, reason, pkt_ok, er, eo, iv, ild, ils, ist, ilw);
      end
      for (int s = 0; s < 2; s++)
         bh[s] = rst ? 4'b0 : {bh[s][2:0], iv[s*3+2] & ilw[s*3+2]};
   endtask

   task automatic nop(input string tag);
      pkt('0, '0, '0, '0, '0, tag);
   endtask

   initial begin
      bh[0] = '0; bh[1] = '0;
      rst = 1'b1;
      // R9: illegal content during reset still reports legal
      pkt(6'b011011, 6'b011011, 6'b011011, 6'b111111, 6'b100100, "R9 reset");
      pkt(6'b111111, 6'b111111, 6'b111111, 6'b111111, 6'b000000, "R9 reset");
      rst = 1'b0;
      nop("R7 empty");
      // R2: one long write per side
      pkt(6'b010001, 6'b010001, 6'b000000, 6'b000000, 6'b000000, "R2 one long per side");
      // R1: two long writes on side B
      pkt(6'b011000, 6'b011000, 6'b000000, 6'b000000, 6'b000000, "R1 double long B");
      // R4: L long write from short sources with store
      pkt(6'b000101, 6'b000001, 6'b000000, 6'b000100, 6'b000000, "R4 store with L long write");
      // R3: L long source with store
      pkt(6'b000101, 6'b000000, 6'b000001, 6'b000100, 6'b000000, "R3 L long src with store");
      // R5: S long source with store
      pkt(6'b000110, 6'b000000, 6'b000010, 6'b000100, 6'b000000, "R5 S long src with store");
      // R10: store on A, S long source on B
      pkt(6'b010100, 6'b000000, 6'b010000, 6'b000100, 6'b000000, "R10 cross side");
      // R10: store flag on L/S slots, load flag on S, long dst on D
      pkt(6'b000111, 6'b000101, 6'b000010, 6'b000011, 6'b000011, "R10 misplaced flags");
      // R7: invalid slots with every flag
      pkt(6'b000000, 6'b111111, 6'b111111, 6'b111111, 6'b111111, "R7 invalid slots");
      for (int k = 0; k < 4; k++) nop("R8 drain");
      // R6 and R8: load to S long write distance sweep on both sides
      for (int s = 0; s < 2; s++) begin
         for (int g = 1; g <= 6; g++) begin
            pkt(6'(4 << (s*3)), '0, '0, '0, 6'(4 << (s*3)), "R6 load issue");
            for (int n = 1; n < g; n++) nop("R8 nop gap");
            pkt(6'(2 << (s*3)), 6'(2 << (s*3)), '0, '0, '0, "R6 R8 distance");
            for (int k = 0; k < 6; k++) nop("R8 drain");
         end
      end
      // R9: load before reset is forgotten
      pkt(6'b000100, '0, '0, '0, 6'b000100, "R9 preload");
      rst = 1'b1;
      nop("R9 reset");
      rst = 1'b0;
      nop("R9 after");
      nop("R9 after");
      pkt(6'b000010, 6'b000010, '0, '0, '0, "R9 history cleared");
      for (int k = 0; k < 4; k++) nop("R8 drain");
      // exhaustive single-side sweeps
      for (int s = 0; s < 2; s++) begin
         for (int p = 0; p < 4096; p++) begin
            logic [11:0] q;
            q = 12'(p);
            pkt(6'(q[2:0] << (s*3)), 6'(q[5:3] << (s*3)), 6'(q[8:6] << (s*3)),
                6'(q[11:9] << (s*3)), '0, "R1 R3 R5 R7 R11 sweep");
         end
      end
      // random mix with loads on both sides
      for (int k = 0; k < 3000; k++) begin
         logic [5:0] rv, rlw;
         rv  = 6'($urandom);
         rlw = 6'($urandom) & 6'b100100 & 6'($urandom);
         pkt(rv, 6'($urandom), 6'($urandom), 6'($urandom), rlw,
             "R1 R3 R5 R6 R8 R10 R11 random");
      end
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_NS * 200000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule